// File: doc/BRIEF.md
# Capture List Control Register Bank

This block is the host-facing control plane for a data capture engine that walks several independent capture lists. Each list owns a block of registers at a fixed 0x80 stride. The host uses these registers to take ownership of the list, arm its trigger, give the list-memory and capture-memory base addresses, set a cycle timeout and manage interrupts. The host then kicks the list with a software trigger. The block holds each accepted trigger as a pending request and hands requests to the engine one per cycle, lowest list first. It also gathers the engine's per-list completion and bus-error events into sticky status bits that software clears by writing ones.

Host access uses a single-cycle write strobe with a word address, and read data that follows the address combinationally. Besides the per-list blocks there is a small global region. It holds a capability register, a list-count register, a busy status register and a broadcast trigger register that can fire several lists in the same cycle. The engine receives a one-cycle start pulse carrying the list number and that list's bases and timeout. It returns done and error events per list.

Top module: `caplist_ctrl`

## Requirements
- R1: The registers of list i sit at address i*0x80 plus these offsets, and each reads back what was written, truncated to its field: ownership bit 0 at 0x00, trigger-enable bit 9 at 0x04, 16-bit list base at 0x08, 16-bit capture base at 0x0C, 12-bit timeout at 0x10, 3-bit interrupt enable at 0x18. The trigger register 0x2C and unused offsets read 0.
- R2: After reset, every register reads 0, no start pulse is issued and the interrupt output is low.
- R3: A trigger, written as bit 0 of offset 0x2C or as bit i of the broadcast register 0x80C, is accepted only if the list has ownership bit 0 and trigger-enable bit 9 both set. Otherwise it leaves no pending request and causes no start.
- R4: An accepted trigger on an idle list produces a one-cycle start pulse two clock edges after the write edge. The pulse carries that list's number, list base, capture base and timeout, and the list becomes running.
- R5: Lists made pending in the same cycle are started one per cycle in ascending list order.
- R6: While a list runs, engine done sets interrupt status bit 0. An engine error code that is not zero sets status bit 1 and is ORed into bus status bits 1:0 at offset 0x30. Either event ends the run. Events on a list that is not running change nothing.
- R7: A nonzero timeout T keeps a run with no engine event going for exactly T cycles, then ends it and sets status bit 2. A timeout of 0 never expires.
- R8: Interrupt status (0x1C) and bus status (0x30) clear only the bits written as 1. A hardware set in the same cycle as a clear wins.
- R9: The interrupt output is high whenever any list has a status bit set whose enable bit is also set.
- R10: Global register 0x800 bit 6 reports the fixed loop-shift capability, 0x804 returns the list count, and 0x808 reports bit 0 = any list running and bit 1 = any request pending.
- R11: Clearing the ownership bit or the trigger-enable bit of a list drops its pending request.
- R12: A trigger accepted while its list is running stays pending and starts the list after that run ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 12 | Host byte address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data for host_addr |
| start_valid | output | 1 | One-cycle start request to the engine |
| start_list | output | 2 | List number being started |
| start_list_base | output | 16 | List-memory base of the started list |
| start_cap_base | output | 16 | Capture-memory base of the started list |
| start_timeout | output | 12 | Timeout of the started list |
| eng_done | input | 4 | Per-list completion event |
| eng_err | input | 8 | Per-list 2-bit bus-error code, list i at bits 2i+1:2i |
| irq | output | 1 | Combined interrupt |

## Verification
Several pairs of functions can land in one cycle. A W1C host write to the bus or interrupt status can arrive while the engine raises an event that sets the same bits. A broadcast trigger can make three lists pending at once, so the arbiter has to serialise them. The bench forces the first case by driving an engine error or done in the same cycle as a W1C write of all ones, and judges the result by reading back the surviving bits. It forces the second with one broadcast write and judges it by the recorded start order and by a per-cycle comparison against a behavioural model.

// File: rtl/caplist_pkg.sv
package caplist_pkg;

    parameter int ADDR_W = 12;
    parameter int DATA_W = 32;
    parameter int BASE_W = 16;
    parameter int TMO_W  = 12;
    parameter int BUS_W  = 2;
    parameter int OFF_W  = 7;

    // Per-list register offsets inside one 0x80 window
    localparam logic [OFF_W-1:0] OFF_OWN   = 7'h00;
    localparam logic [OFF_W-1:0] OFF_CFG   = 7'h04;
    localparam logic [OFF_W-1:0] OFF_LBASE = 7'h08;
    localparam logic [OFF_W-1:0] OFF_CBASE = 7'h0C;
    localparam logic [OFF_W-1:0] OFF_TMO   = 7'h10;
    localparam logic [OFF_W-1:0] OFF_IEN   = 7'h18;
    localparam logic [OFF_W-1:0] OFF_IST   = 7'h1C;
    localparam logic [OFF_W-1:0] OFF_KICK  = 7'h2C;
    localparam logic [OFF_W-1:0] OFF_BUS   = 7'h30;

    localparam int CFG_ARM_BIT    = 9;
    localparam int INFO_SHIFT_BIT = 6;

    // Global region
    localparam logic [ADDR_W-1:0] G_INFO  = 12'h800;
    localparam logic [ADDR_W-1:0] G_COUNT = 12'h804;
    localparam logic [ADDR_W-1:0] G_STAT  = 12'h808;
    localparam logic [ADDR_W-1:0] G_KICK  = 12'h80C;

    typedef struct packed {
        logic tmo;
        logic err;
        logic done;
    } ev_t;

    localparam int EV_W = $bits(ev_t);

    typedef struct packed {
        logic [BASE_W-1:0] lbase;
        logic [BASE_W-1:0] cbase;
        logic [TMO_W-1:0]  tmo;
    } launch_t;

    function automatic logic [EV_W-1:0] sticky_update(
        input logic [EV_W-1:0] cur,
        input logic [EV_W-1:0] clr,
        input logic [EV_W-1:0] set
    );
        return (cur & ~clr) | set;
    endfunction

endpackage

// File: rtl/caplist_slot.sv
module caplist_slot
    import caplist_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [OFF_W-1:0]   off,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               bcast_kick,
    input  logic               grant,
    input  logic               eng_done,
    input  logic [BUS_W-1:0]   eng_err,
    output logic [DATA_W-1:0]  rd_data,
    output logic               pend,
    output logic               run,
    output logic               own,
    output logic               arm,
    output logic               irq,
    output launch_t            launch
);

    logic              own_q, arm_q, pend_q, run_q;
    launch_t           cfg_q;
    logic [EV_W-1:0]   ien_q;
    ev_t               ist_q;
    logic [BUS_W-1:0]  bus_q;
    logic [TMO_W-1:0]  tcnt_q;

    logic              own_n, arm_n, kick, pend_n;
    ev_t               ev;
    logic [EV_W-1:0]   ist_clr;
    logic [BUS_W-1:0]  bus_clr, bus_set;
    logic              unused_hi;

    assign unused_hi = ^wr_data[DATA_W-1:BASE_W];

    always_comb begin
        own_n   = (wr_en && off == OFF_OWN) ? wr_data[0] : own_q;
        arm_n   = (wr_en && off == OFF_CFG) ? wr_data[CFG_ARM_BIT] : arm_q;
        kick    = (wr_en && off == OFF_KICK && wr_data[0]) || bcast_kick;
        ist_clr = (wr_en && off == OFF_IST) ? wr_data[EV_W-1:0] : '0;
        bus_clr = (wr_en && off == OFF_BUS) ? wr_data[BUS_W-1:0] : '0;
        bus_set = run_q ? eng_err : '0;

        ev.done = run_q && eng_done;
        ev.err  = run_q && (eng_err != '0);
        ev.tmo  = run_q && (cfg_q.tmo != '0) && (tcnt_q == cfg_q.tmo - TMO_W'(1))
                  && !eng_done && (eng_err == '0);

        if (grant)
            pend_n = 1'b0;
        else if (kick && own_q && arm_q)
            pend_n = 1'b1;
        else
            pend_n = pend_q;
        pend_n = pend_n && own_n && arm_n;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            own_q  <= 1'b0;
            arm_q  <= 1'b0;
            pend_q <= 1'b0;
            run_q  <= 1'b0;
            cfg_q  <= '0;
            ien_q  <= '0;
            ist_q  <= '0;
            bus_q  <= '0;
            tcnt_q <= '0;
        end else begin
            own_q  <= own_n;
            arm_q  <= arm_n;
            pend_q <= pend_n;
            if (wr_en && off == OFF_LBASE) cfg_q.lbase <= wr_data[BASE_W-1:0];
            if (wr_en && off == OFF_CBASE) cfg_q.cbase <= wr_data[BASE_W-1:0];
            if (wr_en && off == OFF_TMO)   cfg_q.tmo   <= wr_data[TMO_W-1:0];
            if (wr_en && off == OFF_IEN)   ien_q       <= wr_data[EV_W-1:0];
            ist_q <= sticky_update(ist_q, ist_clr, ev);
            bus_q <= (bus_q & ~bus_clr) | bus_set;
            if (grant) begin
                run_q  <= 1'b1;
                tcnt_q <= '0;
            end else if (run_q) begin
                tcnt_q <= tcnt_q + TMO_W'(1);
                if (ev.done || ev.err || ev.tmo)
                    run_q <= 1'b0;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (off)
            OFF_OWN:   rd_data[0]           = own_q;
            OFF_CFG:   rd_data[CFG_ARM_BIT] = arm_q;
            OFF_LBASE: rd_data[BASE_W-1:0]  = cfg_q.lbase;
            OFF_CBASE: rd_data[BASE_W-1:0]  = cfg_q.cbase;
            OFF_TMO:   rd_data[TMO_W-1:0]   = cfg_q.tmo;
            OFF_IEN:   rd_data[EV_W-1:0]    = ien_q;
            OFF_IST:   rd_data[EV_W-1:0]    = ist_q;
            OFF_BUS:   rd_data[BUS_W-1:0]   = bus_q;
            default:   rd_data              = '0;
        endcase
    end

    assign pend   = pend_q;
    assign run    = run_q;
    assign own    = own_q;
    assign arm    = arm_q;
    assign irq    = |(ist_q & ien_q);
    assign launch = cfg_q;

endmodule

// File: rtl/caplist_pick.sv
module caplist_pick #(
    parameter int N  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          valid,
    output logic [IW-1:0] idx,
    output logic [N-1:0]  gnt
);

    always_comb begin
        idx = '0;
        gnt = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
        valid = |req;
        if (valid) gnt[idx] = 1'b1;
    end

endmodule

// File: rtl/caplist_ctrl.sv
module caplist_ctrl
    import caplist_pkg::*;
#(
    parameter int NUM_LISTS        = 4,
    parameter bit LOOP_SHIFT_FIXED = 1'b1,
    localparam int LW    = (NUM_LISTS > 1) ? $clog2(NUM_LISTS) : 1,
    localparam int SEL_W = ADDR_W - 1 - OFF_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       host_we,
    input  logic [ADDR_W-1:0]          host_addr,
    input  logic [DATA_W-1:0]          host_wdata,
    output logic [DATA_W-1:0]          host_rdata,
    output logic                       start_valid,
    output logic [LW-1:0]              start_list,
    output logic [BASE_W-1:0]          start_list_base,
    output logic [BASE_W-1:0]          start_cap_base,
    output logic [TMO_W-1:0]           start_timeout,
    input  logic [NUM_LISTS-1:0]       eng_done,
    input  logic [BUS_W*NUM_LISTS-1:0] eng_err,
    output logic                       irq
);

    logic              in_list;
    logic [SEL_W-1:0]  sel;
    logic [OFF_W-1:0]  off;

    logic [NUM_LISTS-1:0] pend_vec, run_vec, lock_vec, en_vec, irq_vec, gnt_vec;
    logic [DATA_W-1:0]    slot_rd [NUM_LISTS];
    launch_t              lch     [NUM_LISTS];

    logic          pick_valid;
    logic [LW-1:0] pick_idx;

    logic          sv_q;
    logic [LW-1:0] sl_q;
    launch_t       sl_cfg_q;

    assign in_list = ~host_addr[ADDR_W-1];
    assign sel     = host_addr[ADDR_W-2:OFF_W];
    assign off     = host_addr[OFF_W-1:0];

    for (genvar i = 0; i < NUM_LISTS; i++) begin : g_slot
        caplist_slot u_slot (
            .clk        (clk),
            .rst        (rst),
            .wr_en      (host_we && in_list && sel == SEL_W'(i)),
            .off        (off),
            .wr_data    (host_wdata),
            .bcast_kick (host_we && host_addr == G_KICK && host_wdata[i]),
            .grant      (gnt_vec[i]),
            .eng_done   (eng_done[i]),
            .eng_err    (eng_err[BUS_W*i +: BUS_W]),
            .rd_data    (slot_rd[i]),
            .pend       (pend_vec[i]),
            .run        (run_vec[i]),
            .own        (lock_vec[i]),
            .arm        (en_vec[i]),
            .irq        (irq_vec[i]),
            .launch     (lch[i])
        );
    end

    caplist_pick #(.N(NUM_LISTS), .IW(LW)) u_pick (
        .req   (pend_vec & ~run_vec),
        .valid (pick_valid),
        .idx   (pick_idx),
        .gnt   (gnt_vec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sv_q     <= 1'b0;
            sl_q     <= '0;
            sl_cfg_q <= '0;
        end else begin
            sv_q <= pick_valid;
            if (pick_valid) begin
                sl_q     <= pick_idx;
                sl_cfg_q <= lch[pick_idx];
            end
        end
    end

    always_comb begin
        host_rdata = '0;
        if (in_list) begin
            for (int i = 0; i < NUM_LISTS; i++) begin
                if (sel == SEL_W'(i)) host_rdata = slot_rd[i];
            end
        end else begin
            unique case (host_addr)
                G_INFO:  host_rdata[INFO_SHIFT_BIT] = LOOP_SHIFT_FIXED;
                G_COUNT: host_rdata = DATA_W'(NUM_LISTS);
                G_STAT:  host_rdata[1:0] = {|pend_vec, |run_vec};
                default: host_rdata = '0;
            endcase
        end
    end

    assign start_valid     = sv_q;
    assign start_list      = sl_q;
    assign start_list_base = sl_cfg_q.lbase;
    assign start_cap_base  = sl_cfg_q.cbase;
    assign start_timeout   = sl_cfg_q.tmo;
    assign irq             = |irq_vec;

endmodule

// File: rtl/caplist_checker.sv
module caplist_checker #(
    parameter int N  = 4,
    parameter int LW = 2
) (
    input logic          clk,
    input logic          rst,
    input logic          start_valid,
    input logic [LW-1:0] start_list,
    input logic [N-1:0]  pend_vec,
    input logic [N-1:0]  run_vec,
    input logic [N-1:0]  lock_vec,
    input logic [N-1:0]  en_vec
);

    logic [N-1:0] elig_q, run_q, lowmask, rose;

    always_ff @(posedge clk) begin
        if (rst) begin
            elig_q <= '0;
            run_q  <= '0;
        end else begin
            elig_q <= pend_vec & ~run_vec;
            run_q  <= run_vec;
        end
    end

    assign lowmask = (N'(1) << start_list) - N'(1);
    assign rose    = run_vec & ~run_q;

    // R3 / R11: a pending request never outlives ownership or arming
    assert_pend_gated_R3: assert property (@(posedge clk) disable iff (rst)
        (pend_vec & ~(lock_vec & en_vec)) == '0);

    // R4: a start only names a list that was eligible the cycle before
    assert_start_from_pend_R4: assert property (@(posedge clk) disable iff (rst)
        start_valid |-> elig_q[start_list]);

    // R5: no lower-numbered list was eligible when this one was started
    assert_start_order_R5: assert property (@(posedge clk) disable iff (rst)
        start_valid |-> (elig_q & lowmask) == '0);

    // R4: a list becomes running only together with its own start pulse
    assert_run_rise_R4: assert property (@(posedge clk) disable iff (rst)
        (rose != '0) |-> (start_valid && rose == (N'(1) << start_list)));

    // R5: at most one list starts per cycle
    assert_single_start_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rose));

endmodule

bind caplist_ctrl caplist_checker #(.N(NUM_LISTS), .LW(LW)) u_caplist_checker (
    .clk         (clk),
    .rst         (rst),
    .start_valid (start_valid),
    .start_list  (start_list),
    .pend_vec    (pend_vec),
    .run_vec     (run_vec),
    .lock_vec    (lock_vec),
    .en_vec      (en_vec)
);

// File: tb/caplist_ctrl_bench.sv
`timescale 1ns/1ps
module caplist_ctrl_bench;

    localparam int N = 4;
    localparam int WATCHDOG = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_we = 1'b0;
    logic [11:0] host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        start_valid;
    logic [1:0]  start_list;
    logic [15:0] start_list_base, start_cap_base;
    logic [11:0] start_timeout;
    logic [3:0]  eng_done = '0;
    logic [7:0]  eng_err = '0;
    logic        irq;

    always #2 clk = ~clk;

    caplist_ctrl u_caplist_ctrl (
        .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .start_valid(start_valid), .start_list(start_list),
        .start_list_base(start_list_base), .start_cap_base(start_cap_base),
        .start_timeout(start_timeout), .eng_done(eng_done), .eng_err(eng_err),
        .irq(irq)
    );

    int vectors = 0;
    int fails = 0;
    int cyc = 0;
    bit finished = 1'b0;
    string cur_tag = "R2";
    int start_log[$];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit          m_lock[N], m_en[N], m_pend[N], m_run[N];
    logic [15:0] m_lb[N], m_cb[N];
    logic [11:0] m_tmo[N], m_tcnt[N];
    logic [2:0]  m_ie[N], m_ist[N];
    logic [1:0]  m_bus[N];
    bit          m_sv;
    int          m_sl;
    logic [15:0] m_slb, m_scb;
    logic [11:0] m_stmo;

    always @(posedge clk) begin
        int g;
        bit wsel, trig, de, ee, te, nlock, nen, npend;
        logic [6:0] o;
        logic [1:0] code;
        logic [2:0] iclr;
        logic [1:0] bclr;
        if (rst) begin
            for (int i = 0; i < N; i++) begin
                m_lock[i] = 0; m_en[i] = 0; m_pend[i] = 0; m_run[i] = 0;
                m_lb[i] = 0; m_cb[i] = 0; m_tmo[i] = 0; m_tcnt[i] = 0;
                m_ie[i] = 0; m_ist[i] = 0; m_bus[i] = 0;
            end
            m_sv = 0; m_sl = 0; m_slb = 0; m_scb = 0; m_stmo = 0;
        end else begin
            g = -1;
            for (int i = 0; i < N; i++)
                if (g < 0 && m_pend[i] && !m_run[i]) g = i;
            m_sv = (g >= 0);
            if (g >= 0) begin
                m_sl = g; m_slb = m_lb[g]; m_scb = m_cb[g]; m_stmo = m_tmo[g];
            end
            o = host_addr[6:0];
            for (int i = 0; i < N; i++) begin
                wsel  = host_we && !host_addr[11] && (host_addr[10:7] == i);
                nlock = (wsel && o == 7'h00) ? host_wdata[0] : m_lock[i];
                nen   = (wsel && o == 7'h04) ? host_wdata[9] : m_en[i];
                trig  = (wsel && o == 7'h2C && host_wdata[0]) ||
                        (host_we && host_addr == 12'h80C && host_wdata[i]);
                code  = eng_err[2*i +: 2];
                de = m_run[i] && eng_done[i];
                ee = m_run[i] && code != 0;
                te = m_run[i] && m_tmo[i] != 0 && m_tcnt[i] == m_tmo[i] - 12'd1 &&
                     !eng_done[i] && code == 0;
                if (g == i) npend = 0;
                else if (trig && m_lock[i] && m_en[i]) npend = 1;
                else npend = m_pend[i];
                npend = npend && nlock && nen;
                iclr = (wsel && o == 7'h1C) ? host_wdata[2:0] : 3'b000;
                bclr = (wsel && o == 7'h30) ? host_wdata[1:0] : 2'b00;
                m_ist[i] = (m_ist[i] & ~iclr) | {te, ee, de};
                m_bus[i] = (m_bus[i] & ~bclr) | (m_run[i] ? code : 2'b00);
                if (g == i) begin
                    m_run[i] = 1; m_tcnt[i] = 0;
                end else if (m_run[i]) begin
                    m_tcnt[i] = m_tcnt[i] + 12'd1;
                    if (de || ee || te) m_run[i] = 0;
                end
                if (wsel && o == 7'h08) m_lb[i]  = host_wdata[15:0];
                if (wsel && o == 7'h0C) m_cb[i]  = host_wdata[15:0];
                if (wsel && o == 7'h10) m_tmo[i] = host_wdata[11:0];
                if (wsel && o == 7'h18) m_ie[i]  = host_wdata[2:0];
                m_lock[i] = nlock; m_en[i] = nen; m_pend[i] = npend;
            end
        end
    end

    function automatic logic [31:0] model_rd(input logic [11:0] a);
        int li;
        bit anyp, anyr;
        logic [31:0] r;
        r = 0;
        if (!a[11]) begin
            li = a[10:7];
            if (li < N) begin
                case (a[6:0])
                    7'h00: r = {31'd0, m_lock[li]};
                    7'h04: r = m_en[li] ? 32'h200 : 32'h0;
                    7'h08: r = {16'd0, m_lb[li]};
                    7'h0C: r = {16'd0, m_cb[li]};
                    7'h10: r = {20'd0, m_tmo[li]};
                    7'h18: r = {29'd0, m_ie[li]};
                    7'h1C: r = {29'd0, m_ist[li]};
                    7'h30: r = {30'd0, m_bus[li]};
                    default: r = 0;
                endcase
            end
        end else begin
            anyp = 0; anyr = 0;
            for (int i = 0; i < N; i++) begin
                anyp |= m_pend[i]; anyr |= m_run[i];
            end
            case (a)
                12'h800: r = 32'h40;
                12'h804: r = N;
                12'h808: r = {30'd0, anyp, anyr};
                default: r = 0;
            endcase
        end
        return r;
    endfunction

    function automatic bit model_irq();
        bit v;
        v = 0;
        for (int i = 0; i < N; i++) v |= |(m_ist[i] & m_ie[i]);
        return v;
    endfunction

    // ---------------- per-cycle comparison ----------------
    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk(start_valid == m_sv, "R4 start_valid", {31'd0, start_valid}, {31'd0, m_sv});
            if (m_sv && start_valid) begin
                chk(start_list == m_sl[1:0], "R5 start_list", {30'd0, start_list}, m_sl);
                chk(start_list_base == m_slb, "R4 list_base", {16'd0, start_list_base}, {16'd0, m_slb});
                chk(start_cap_base == m_scb, "R4 cap_base", {16'd0, start_cap_base}, {16'd0, m_scb});
                chk(start_timeout == m_stmo, "R4 timeout", {20'd0, start_timeout}, {20'd0, m_stmo});
            end
            chk(irq == model_irq(), "R9 irq", {31'd0, irq}, {31'd0, model_irq()});
            chk(host_rdata == model_rd(host_addr), {cur_tag, " rdata"}, host_rdata, model_rd(host_addr));
            if (start_valid) start_log.push_back(int'(start_list));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        host_we = 1; host_addr = a; host_wdata = d;
        @(posedge clk); #1;
        host_we = 0; host_wdata = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic rd_check(input logic [11:0] a, input logic [31:0] exp, input string tag);
        host_addr = a;
        @(negedge clk);
        chk(host_rdata == exp, tag, host_rdata, exp);
        @(posedge clk); #1;
    endtask

    task automatic done_pulse(input logic [3:0] m);
        eng_done = m;
        @(posedge clk); #1;
        eng_done = 0;
    endtask

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG && !finished) begin
            finished = 1;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, WATCHDOG);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    // ---------------- directed sequence ----------------
    initial begin
        int cnt;
        repeat (3) @(posedge clk);
        #1 rst = 0;

        // R2: reset state
        cur_tag = "R2";
        @(negedge clk);
        chk(start_valid == 0, "R2 no start after reset", {31'd0, start_valid}, 0);
        chk(irq == 0, "R2 irq low after reset", {31'd0, irq}, 0);
        @(posedge clk); #1;
        rd_check(12'h008, 0, "R2 list0 base");
        rd_check(12'h184, 0, "R2 list3 config");
        rd_check(12'h808, 0, "R2 global status");

        // R1: map and field truncation
        cur_tag = "R1";
        for (int i = 0; i < N; i++) begin
            wr(12'(i*128 + 8),  32'hFFFF_1230 + i);
            wr(12'(i*128 + 12), 32'hABCD_4560 + i);
            wr(12'(i*128 + 16), 32'hFFFF_F7AB);
            wr(12'(i*128 + 24), 32'hFFFF_FFFF);
            wr(12'(i*128 + 0),  32'hFFFF_FFFF);
            wr(12'(i*128 + 4),  32'hFFFF_FFFF);
        end
        for (int i = 0; i < N; i++) begin
            rd_check(12'(i*128 + 8),  32'h1230 + i, "R1 list base");
            rd_check(12'(i*128 + 12), 32'h4560 + i, "R1 capture base");
            rd_check(12'(i*128 + 16), 32'h7AB, "R1 timeout");
            rd_check(12'(i*128 + 24), 32'h7, "R1 irq enable");
            rd_check(12'(i*128 + 0),  32'h1, "R1 ownership");
            rd_check(12'(i*128 + 4),  32'h200, "R1 trigger enable");
        end
        rd_check(12'h0AC, 0, "R1 trigger reads zero");
        rd_check(12'h014, 0, "R1 unused offset");
        for (int i = 0; i < N; i++) begin
            wr(12'(i*128 + 16), 0);
            wr(12'(i*128 + 24), 0);
        end
        wr(12'h080, 0);       // list1 unowned, armed
        wr(12'h104, 0);       // list2 owned, not armed
        wr(12'h180, 0);       // list3 neither
        wr(12'h184, 0);

        // R3: gated trigger
        cur_tag = "R3";
        start_log.delete();
        wr(12'h0AC, 1);
        wr(12'h12C, 1);
        wr(12'h1AC, 1);
        idle(3);
        chk(start_log.size() == 0, "R3 ungated lists did not start", start_log.size(), 0);
        rd_check(12'h808, 0, "R3 nothing pending");

        // R4: accepted trigger on list0
        cur_tag = "R4";
        wr(12'h02C, 1);
        idle(3);
        chk(start_log.size() == 1 && start_log[0] == 0, "R4 list0 started once", start_log.size(), 1);
        rd_check(12'h808, 1, "R4 list0 running");

        // R12: trigger while running waits for the run to end
        cur_tag = "R12";
        wr(12'h02C, 1);
        rd_check(12'h808, 3, "R12 pending while running");
        done_pulse(4'b0001);
        idle(3);
        chk(start_log.size() == 2, "R12 restart after done", start_log.size(), 2);
        rd_check(12'h01C, 1, "R6 done status bit0");

        // R11: disarm drops a pending request
        cur_tag = "R11";
        wr(12'h02C, 1);
        rd_check(12'h808, 3, "R11 pending before disarm");
        wr(12'h004, 0);
        rd_check(12'h808, 1, "R11 pending dropped");
        done_pulse(4'b0001);
        idle(3);
        chk(start_log.size() == 2, "R11 no start after disarm", start_log.size(), 2);
        wr(12'h004, 32'h200);

        // R6: stray events on an idle list
        cur_tag = "R6";
        done_pulse(4'b0010);
        eng_err = 8'b0000_1100; @(posedge clk); #1; eng_err = 0;
        rd_check(12'h09C, 0, "R6 stray done ignored");
        rd_check(12'h0B0, 0, "R6 stray error ignored");

        // R8: write-one-to-clear
        cur_tag = "R8";
        wr(12'h01C, 0);
        rd_check(12'h01C, 1, "R8 zero write keeps bits");
        wr(12'h01C, 2);
        rd_check(12'h01C, 1, "R8 other bit write keeps bit0");
        wr(12'h01C, 1);
        rd_check(12'h01C, 0, "R8 one clears");
        wr(12'h02C, 1);
        idle(2);
        eng_err = 8'b0000_0010;
        wr(12'h030, 3);
        eng_err = 0;
        rd_check(12'h030, 2, "R8 set beats clear on bus status");
        rd_check(12'h01C, 2, "R6 error sets bit1");
        wr(12'h030, 2);
        rd_check(12'h030, 0, "R8 bus status cleared");
        wr(12'h02C, 1);
        idle(2);
        eng_done = 4'b0001;
        wr(12'h01C, 7);
        eng_done = 0;
        rd_check(12'h01C, 1, "R8 set beats clear on irq status");

        // R7: timeout of 5 cycles on list3
        cur_tag = "R7";
        wr(12'h180, 1);
        wr(12'h184, 32'h200);
        wr(12'h190, 5);
        wr(12'h1AC, 1);
        host_addr = 12'h808;
        cnt = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (host_rdata[0]) cnt++;
        end
        @(posedge clk); #1;
        chk(cnt == 5, "R7 run length equals timeout", cnt, 5);
        rd_check(12'h19C, 4, "R7 timeout status bit2");
        wr(12'h190, 0);

        // R5: broadcast trigger, ascending start order
        cur_tag = "R5";
        wr(12'h104, 32'h200);
        start_log.delete();
        wr(12'h80C, 32'hF);
        idle(4);
        chk(start_log.size() == 3, "R5 three starts", start_log.size(), 3);
        if (start_log.size() == 3) begin
            chk(start_log[0] == 0, "R5 first is list0", start_log[0], 0);
            chk(start_log[1] == 2, "R5 second is list2", start_log[1], 2);
            chk(start_log[2] == 3, "R5 third is list3", start_log[2], 3);
        end
        done_pulse(4'hF);
        idle(1);

        // R9: interrupt combine
        cur_tag = "R9";
        wr(12'h018, 1);
        @(negedge clk);
        chk(irq == 1, "R9 irq with enabled status", {31'd0, irq}, 1);
        @(posedge clk); #1;
        wr(12'h018, 2);
        @(negedge clk);
        chk(irq == 0, "R9 irq masked", {31'd0, irq}, 0);
        @(posedge clk); #1;

        // R10: global registers
        cur_tag = "R10";
        rd_check(12'h800, 32'h40, "R10 loop shift flag");
        rd_check(12'h804, 4, "R10 list count");
        rd_check(12'h808, 0, "R10 idle status");

        idle(2);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule